// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Mode Tracker

This block follows, edge by edge, the power mode that a single-data-rate SDRAM is in as the controller drives its clock-enable pin. On every rising clock edge it registers the clock-enable level and a pre-decoded command. It judges the pair formed by the clock-enable level on the previous edge and the level on the current edge, together with the present mode and the command. The result is the mode the device holds from the next edge onward: banks idle, bursting (reading or writing), power-down, self refresh, clock suspend, or the recovery window that follows a self-refresh exit.

It is meant to sit beside an SDRAM controller or a memory model, where it acts as a protocol monitor. `mode_o` tells the rest of the design what the device is doing. `cmd_accept_o` shows whether a command issued now would be taken. `illegal_o` latches the first sequence that breaks the clock-enable rules. The length of the self-refresh recovery window comes from an input and is counted in clock cycles. A separate input reports whether clock-enable setup time was met on a power-down exit.

Command code on `cmd_i`: 0 = inhibit, 1 = NOP, 2 = auto refresh, 3 = read or write, 4 to 7 = any other valid command. Mode code on `mode_o`: 0 = idle, 1 = bursting, 2 = power-down, 3 = self refresh, 4 = clock suspend, 5 = self-refresh recovery.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset, mode_o is 0 (idle), cmd_accept_o is 1 and illegal_o is 0. The previous clock-enable sample is taken as high, so a low clock-enable on the first edge counts as a high-to-low change.
- R2: When clock-enable is low on both the previous and the current edge in mode 2, 3 or 4, the mode does not change and cmd_i has no effect, including on illegal_o.
- R3: On a low-to-high clock-enable change out of mode 2, 3 or 4, a command other than 0 or 1 sets illegal_o.
- R4: A high-to-low clock-enable change in mode 0 with command 0 or 1 moves the block to mode 2 on that edge.
- R5: A high-to-low clock-enable change in mode 0 with command 2 moves the block to mode 3. With command 3 to 7, illegal_o is set and the mode stays 0.
- R6: A high-to-low clock-enable change in mode 1 moves the block to mode 4, whatever the command.
- R7: A low-to-high change out of mode 2 gives mode 0 from that edge. If setup_ok_i is low on that edge, illegal_o is set as well.
- R8: A low-to-high change out of mode 4 gives mode 1 and cmd_accept_o = 1, so the next edge takes a command.
- R9: A low-to-high change out of mode 3 gives mode 5, which latches xsr_cycles_i. The block returns to mode 0 on the first edge with clock-enable high where at least xsr_cycles_i edges have passed in mode 5 and at least two NOPs (code 1) have been seen there.
- R10: In mode 5, a command other than 0 or 1, or clock-enable going low, sets illegal_o.
- R11: With clock-enable high on both edges, command 3 moves mode 0 to mode 1, and burst_done_i moves mode 1 back to mode 0.
- R12: cmd_accept_o is 1 only in modes 0 and 1. illegal_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_i | input | 1 | Clock-enable level driven to the SDRAM |
| cmd_i | input | 3 | Decoded command: 0 inhibit, 1 NOP, 2 auto refresh, 3 read/write, 4-7 other |
| burst_done_i | input | 1 | Current read or write burst has finished |
| setup_ok_i | input | 1 | Clock-enable setup time met on this edge |
| xsr_cycles_i | input | XSR_W | Self-refresh recovery length in cycles, latched at exit |
| mode_o | output | 3 | Present power mode, coded as above |
| cmd_accept_o | output | 1 | A command on the next edge would be accepted |
| illegal_o | output | 1 | Sticky illegal clock-enable sequence flag |

## Verification
The bench builds the tracker with a 4-bit recovery count and a two-stage reset synchronizer. With these values, recovery windows of 2 and 4 cycles can be set, so both endings of the window can be reached: one where the cycle count runs out before the second NOP arrives, and one where both NOPs come early and the count sets the exit. The two-stage synchronizer means each scenario starts after only a few edges of reset. That keeps every entry and exit path, as well as the illegal cases, within a short directed run.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_ACTIVE  = 3'd1,
    MODE_PWRDN   = 3'd2,
    MODE_SELFREF = 3'd3,
    MODE_SUSPEND = 3'd4,
    MODE_RECOVER = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    CKE_LL = 2'b00,
    CKE_LH = 2'b01,
    CKE_HL = 2'b10,
    CKE_HH = 2'b11
  } cke_pair_e;

  localparam int CMD_W = 3;

  typedef struct packed {
    logic quiet;  // inhibit or NOP
    logic nop;
    logic aref;
    logic rw;
  } cmd_flags_t;

  function automatic cmd_flags_t decode_cmd(input logic [CMD_W-1:0] code);
    cmd_flags_t f;
    f.nop   = (code == 3'd1);
    f.quiet = (code == 3'd0) || (code == 3'd1);
    f.aref  = (code == 3'd2);
    f.rw    = (code == 3'd3);
    return f;
  endfunction

endpackage

// File: rtl/cke_rst_sync.sv
module cke_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cke_pair_tracker.sv
module cke_pair_tracker
  import cke_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke_i,
  output cke_pair_e pair_o
);
  logic cke_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev_q <= 1'b1;
    else        cke_prev_q <= cke_i;
  end

  assign pair_o = cke_pair_e'({cke_prev_q, cke_i});
endmodule

// File: rtl/cke_recovery_win.sv
module cke_recovery_win #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             nop_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [1:0]       NOP_NEED = 2'd2;

  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] elap_q, elap_d, elap_inc;
  logic [1:0]       nops_q, nops_d, nops_inc;
  logic             win_en;

  always_comb begin
    elap_inc = (elap_q == CNT_MAX) ? elap_q : elap_q + 1'b1;
    nops_inc = (nop_i && nops_q != NOP_NEED) ? nops_q + 2'd1 : nops_q;
    win_en   = start_i | active_i;
    if (start_i) begin
      lim_d  = limit_i;
      elap_d = '0;
      nops_d = 2'd0;
    end else begin
      lim_d  = lim_q;
      elap_d = elap_inc;
      nops_d = nops_inc;
    end
    done_o = active_i && (elap_inc >= lim_q) && (nops_inc == NOP_NEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      elap_q <= '0;
      nops_q <= 2'd0;
    end else if (win_en) begin
      lim_q  <= lim_d;
      elap_q <= elap_d;
      nops_q <= nops_d;
    end
  end

  AST_WIN_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && (({1'b0, elap_q} + 1'b1) < {1'b0, lim_q})) |-> !done_o); // R9
  AST_WIN_TWO_NOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && nops_q == 2'd0) |-> !done_o); // R9
endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cke_pair_e  pair_i,
  input  cmd_flags_t cmd_i,
  input  logic       burst_done_i,
  input  logic       setup_ok_i,
  input  logic       win_done_i,
  output logic       win_start_o,
  output logic       win_active_o,
  output mode_e      mode_o,
  output logic       illegal_o
);
  mode_e mode_q, mode_d;
  logic  illegal_q, illegal_d;
  logic  bad;
  logic  mode_en;
  logic  low_power;

  assign low_power = (mode_q == MODE_PWRDN) || (mode_q == MODE_SELFREF) ||
                     (mode_q == MODE_SUSPEND);

  always_comb begin
    mode_d       = mode_q;
    bad          = 1'b0;
    win_start_o  = 1'b0;
    win_active_o = 1'b0;
    unique case (pair_i)
      CKE_LL: begin
        if (!low_power) bad = 1'b1;
      end
      CKE_LH: begin
        if (!cmd_i.quiet) bad = 1'b1;
        case (mode_q)
          MODE_PWRDN: begin
            mode_d = MODE_IDLE;
            if (!setup_ok_i) bad = 1'b1;
          end
          MODE_SELFREF: begin
            mode_d      = MODE_RECOVER;
            win_start_o = 1'b1;
          end
          MODE_SUSPEND: mode_d = MODE_ACTIVE;
          default:      bad = 1'b1;
        endcase
      end
      CKE_HL: begin
        case (mode_q)
          MODE_IDLE: begin
            if (cmd_i.quiet)     mode_d = MODE_PWRDN;
            else if (cmd_i.aref) mode_d = MODE_SELFREF;
            else                 bad = 1'b1;
          end
          MODE_ACTIVE: mode_d = MODE_SUSPEND;
          default:     bad = 1'b1;
        endcase
      end
      CKE_HH: begin
        case (mode_q)
          MODE_IDLE: begin
            if (cmd_i.rw) mode_d = MODE_ACTIVE;
          end
          MODE_ACTIVE: begin
            if (burst_done_i) mode_d = MODE_IDLE;
          end
          MODE_RECOVER: begin
            win_active_o = 1'b1;
            if (!cmd_i.quiet) bad = 1'b1;
            if (win_done_i)   mode_d = MODE_IDLE;
          end
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
    mode_en   = (mode_d != mode_q);
    illegal_d = illegal_q | bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_IDLE;
      illegal_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (bad)     illegal_q <= illegal_d;
    end
  end

  assign mode_o    = mode_q;
  assign illegal_o = illegal_q;

  AST_LL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_LL && low_power) |=> $stable(mode_q)); // R2
  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_HL && mode_q == MODE_IDLE && cmd_i.aref) |=> (mode_q == MODE_SELFREF)); // R5
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_HL && mode_q == MODE_ACTIVE) |=> (mode_q == MODE_SUSPEND)); // R6
  AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_LH && mode_q == MODE_PWRDN) |=> (mode_q == MODE_IDLE)); // R7
  AST_SUSP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_LH && mode_q == MODE_SUSPEND) |=> (mode_q == MODE_ACTIVE)); // R8
  AST_SR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_i == CKE_LH && mode_q == MODE_SELFREF) |=> (mode_q == MODE_RECOVER)); // R9
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |=> illegal_q); // R12
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_trk_pkg::*;
#(
  parameter int XSR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic [2:0]       cmd_i,
  input  logic             burst_done_i,
  input  logic             setup_ok_i,
  input  logic [XSR_W-1:0] xsr_cycles_i,
  output logic [2:0]       mode_o,
  output logic             cmd_accept_o,
  output logic             illegal_o
);
  logic       rst_n_s;
  cke_pair_e  pair;
  cmd_flags_t flags;
  logic       win_start, win_active, win_done;
  mode_e      mode;

  assign flags = decode_cmd(cmd_i);

  cke_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cke_pair_tracker u_pair (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cke_i  (cke_i),
    .pair_o (pair)
  );

  cke_recovery_win #(.CNT_W(XSR_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (win_start),
    .active_i (win_active),
    .nop_i    (flags.nop),
    .limit_i  (xsr_cycles_i),
    .done_o   (win_done)
  );

  cke_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .pair_i       (pair),
    .cmd_i        (flags),
    .burst_done_i (burst_done_i),
    .setup_ok_i   (setup_ok_i),
    .win_done_i   (win_done),
    .win_start_o  (win_start),
    .win_active_o (win_active),
    .mode_o       (mode),
    .illegal_o    (illegal_o)
  );

  assign mode_o       = mode;
  assign cmd_accept_o = (mode == MODE_IDLE) || (mode == MODE_ACTIVE);

  AST_ACCEPT_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_o == 3'd2 || mode_o == 3'd3 || mode_o == 3'd4 || mode_o == 3'd5) |-> !cmd_accept_o); // R12
endmodule

// File: tb/cke_power_tracker_tb_top.sv
module cke_power_tracker_tb_top;
  localparam int XW = 4;
  localparam logic [2:0] C_INH = 3'd0, C_NOP = 3'd1, C_AREF = 3'd2, C_RW = 3'd3, C_OTH = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke, bd, su;
  logic [2:0]    cmd;
  logic [XW-1:0] xsr;
  logic [2:0]    mode;
  logic          acc, ill;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  cke_power_tracker #(.XSR_W(XW), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke_i        (cke),
    .cmd_i        (cmd),
    .burst_done_i (bd),
    .setup_ok_i   (su),
    .xsr_cycles_i (xsr),
    .mode_o       (mode),
    .cmd_accept_o (acc),
    .illegal_o    (ill)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int m, input int a, input int i);
    chk(req, "mode", int'(mode), m);
    chk(req, "accept", int'(acc), a);
    chk(req, "illegal", int'(ill), i);
  endtask

  // drive at a falling edge, let one rising edge register it, return at the next falling edge
  task automatic cyc(input logic c, input logic [2:0] k, input logic b = 1'b0, input logic s = 1'b1);
    cke = c; cmd = k; bd = b; su = s;
    @(negedge clk);
  endtask

  task automatic do_reset(input int x);
    rst_n = 1'b0; cke = 1'b1; cmd = C_NOP; bd = 1'b0; su = 1'b1; xsr = XW'(x);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2);
    chk_state("R1", 0, 1, 0);
    cyc(1'b0, C_NOP);
    chk("R1", "first-edge low cke enters power-down", int'(mode), 2);
  endtask

  task automatic t_powerdown;
    do_reset(2);
    cyc(1'b0, C_INH);
    chk_state("R4", 2, 0, 0);
    cyc(1'b0, C_RW);
    chk_state("R2", 2, 0, 0);
    cyc(1'b0, C_AREF);
    chk_state("R2", 2, 0, 0);
    cyc(1'b1, C_NOP, 1'b0, 1'b1);
    chk_state("R7", 0, 1, 0);
  endtask

  task automatic t_pd_nosetup;
    do_reset(2);
    cyc(1'b0, C_NOP);
    cyc(1'b1, C_NOP, 1'b0, 1'b0);
    chk_state("R7", 0, 1, 1);
    cyc(1'b1, C_NOP);
    cyc(1'b1, C_NOP);
    chk("R12", "illegal sticky", int'(ill), 1);
  endtask

  task automatic t_selfref_count;
    do_reset(4);
    cyc(1'b0, C_AREF);
    chk_state("R5", 3, 0, 0);
    cyc(1'b0, C_RW);
    chk_state("R2", 3, 0, 0);
    cyc(1'b1, C_NOP);
    chk_state("R9", 5, 0, 0);
    xsr = XW'(1); // latched at exit; must not shorten the window
    cyc(1'b1, C_NOP);
    chk("R9", "recover after 1", int'(mode), 5);
    cyc(1'b1, C_INH);
    chk("R9", "recover after 2", int'(mode), 5);
    cyc(1'b1, C_NOP);
    chk("R9", "recover after 3 (two NOPs seen)", int'(mode), 5);
    cyc(1'b1, C_INH);
    chk_state("R9", 0, 1, 0);
  endtask

  task automatic t_selfref_nops;
    do_reset(2);
    cyc(1'b0, C_AREF);
    cyc(1'b1, C_INH);
    chk("R9", "recover entered", int'(mode), 5);
    cyc(1'b1, C_NOP);
    cyc(1'b1, C_INH);
    chk("R9", "count met, one NOP", int'(mode), 5);
    cyc(1'b1, C_INH);
    chk("R9", "still one NOP", int'(mode), 5);
    cyc(1'b1, C_NOP);
    chk_state("R9", 0, 1, 0);
  endtask

  task automatic t_selfref_bad;
    do_reset(2);
    cyc(1'b0, C_AREF);
    cyc(1'b1, C_NOP);
    cyc(1'b1, C_RW);
    chk("R10", "command in recovery", int'(ill), 1);
    do_reset(2);
    cyc(1'b0, C_AREF);
    cyc(1'b1, C_NOP);
    cyc(1'b0, C_NOP);
    chk("R10", "cke low in recovery", int'(ill), 1);
  endtask

  task automatic t_suspend;
    do_reset(2);
    cyc(1'b1, C_RW);
    chk_state("R11", 1, 1, 0);
    cyc(1'b0, C_OTH);
    chk_state("R6", 4, 0, 0);
    cyc(1'b0, C_RW);
    chk_state("R2", 4, 0, 0);
    cyc(1'b1, C_NOP);
    chk_state("R8", 1, 1, 0);
    cyc(1'b1, C_NOP, 1'b1);
    chk_state("R11", 0, 1, 0);
  endtask

  task automatic t_bad_edges;
    do_reset(2);
    cyc(1'b0, C_NOP);
    cyc(1'b1, C_RW);
    chk("R3", "non-quiet exit command", int'(ill), 1);
    do_reset(2);
    cyc(1'b0, C_RW);
    chk_state("R5", 0, 1, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cmd = C_NOP; bd = 1'b0; su = 1'b1; xsr = '0;
    t_reset();
    t_powerdown();
    t_pd_nosetup();
    t_selfref_count();
    t_selfref_nops();
    t_selfref_bad();
    t_suspend();
    t_bad_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule